// File: doc/BRIEF.md
# Staircase multilevel inverter gate sequencer

This block drives the gates of a single-phase cascaded multilevel inverter that runs at the fundamental frequency, with no carrier and no sampling. The power stage is a series chain of one auxiliary cell, a parameterised number of three-source basic units and an output H-bridge. All DC sources are equal. With the default of two units the stage reaches fifteen output levels, from -7 to +7 source voltages.

A programmable prescaler divides the system clock into a row strobe. On each strobe a row counter selects one signed level from a one-period staircase table, and the table has 500 rows by default. The level is split into an auxiliary-cell state, one of three legal states per basic unit and an H-bridge polarity. Before the gate word reaches the registered outputs, each unit word is screened for switch combinations that would short a source.

For a 50 Hz output with 500 rows, the row rate is 25 kHz, which needs a divider of 8000 at 200 MHz. The block is used by setting that divider.

Top module: `stair_gate_seq`

## Requirements
- R1: While reset is high at a clock edge, all gate outputs and the short flag are 0 after that edge.
- R2: Gate outputs update once every `div_i` clock edges. A `div_i` of 0 behaves as 1.
- R3: Each update takes the next table row, starting at row 0 after reset. After row ROWS-1 the next row is row 0.
- R4: Row k holds a level of magnitude floor((32·p·A + d) / (2·d)), where h = ROWS/2, t = k mod h, p = t·(h−t), d = 5h²−4p and A = 3·units+1. The level is negative for k ≥ h.
- R5: For magnitude m, let q = m/3 and r = m mod 3. Units below q take state "three" (word 5'b00111). Unit q takes state "two" (5'b01101) if r = 2. Every other unit takes "zero" (5'b10000). Unit word bits are {S5,S4,S3,S2,S1}, and unit u occupies bits 5u+4..5u.
- R6: The auxiliary word {S2,S1} is 2'b01 (adds one source) when r = 1, and 2'b10 (bypass) otherwise.
- R7: The H-bridge word {T4,T3,T2,T1} is 4'b1001 for a positive level and 4'b0110 for a negative level.
- R8: At a zero level the H-bridge word keeps its previous value. Directly after reset that value is 4'b0000.
- R9: No registered unit word ever has S2 and S4 both on, or S1, S3, S4 and S5 all on, or S1, S2, S3 and S5 all on. A unit word that would do so is forced to all-off and the short flag is raised. For every table level the flag stays 0.
- R10: Between row updates, every gate output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_i | input | DIV_W | Clock edges per table row |
| aux_gate_o | output | 2 | Auxiliary cell gates {S2,S1} |
| unit_gate_o | output | 5·NUM_UNITS | Basic unit gates, unit u at bits 5u+4..5u |
| hb_gate_o | output | 4 | H-bridge gates {T4,T3,T2,T1} |
| short_flag_o | output | 1 | A unit word was suppressed for a short hazard |

## Verification
A row counter that slips or wraps at the wrong place shows up at the outputs on the very next strobe, because every row's full gate word is compared with a value computed from the table formula. A wrong decomposition or polarity shows up in the word of the affected row. A polarity register that drops its value shows up only at zero rows, after a non-zero half-cycle. The sweep therefore crosses both zero crossings and both table wraps at several divider settings. Gate words are also sampled between strobes, so a prescaler fault that moves an update by even one clock is caught within one row.

// File: rtl/stair_pkg.sv
`timescale 1ns/1ps
package stair_pkg;
   localparam int UNIT_W = 5;

   // unit word {S5,S4,S3,S2,S1}
   localparam logic [UNIT_W-1:0] UNIT_ZERO  = 5'b10000;
   localparam logic [UNIT_W-1:0] UNIT_TWO   = 5'b01101;
   localparam logic [UNIT_W-1:0] UNIT_THREE = 5'b00111;

   // auxiliary word {S2,S1}
   localparam logic [1:0] AUX_ADD = 2'b01;
   localparam logic [1:0] AUX_BYP = 2'b10;

   // H-bridge word {T4,T3,T2,T1}
   localparam logic [3:0] HB_OFF = 4'b0000;
   localparam logic [3:0] HB_POS = 4'b1001;
   localparam logic [3:0] HB_NEG = 4'b0110;

   function automatic logic short_hazard(input logic [UNIT_W-1:0] w);
      return (w[1] & w[3]) |
             (w[0] & w[2] & w[3] & w[4]) |
             (w[0] & w[1] & w[2] & w[4]);
   endfunction

   // staircase magnitude of row k, integer sine approximation over a half period
   function automatic int row_mag(input int k, input int rows, input int amp);
      int h, t, p, num, den;
      h   = rows / 2;
      t   = (k < h) ? k : k - h;
      p   = t * (h - t);
      num = 16 * p * amp;
      den = 5 * h * h - 4 * p;
      return (2 * num + den) / (2 * den);
   endfunction
endpackage

// File: rtl/stair_tick_gen.sv
`timescale 1ns/1ps
module stair_tick_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim;

   assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
   assign tick_o = (cnt_q >= lim);

   always_ff @(posedge clk) begin
      if (rst)         cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   // R2: between strobes the count advances by exactly one
   p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
      !tick_o |=> cnt_q == $past(cnt_q) + 1'b1);
   // R2: a strobe restarts the interval
   p_count_restart_r2: assert property (@(posedge clk) disable iff (rst)
      tick_o |=> cnt_q == '0);
endmodule

// File: rtl/stair_level_table.sv
`timescale 1ns/1ps
module stair_level_table #(
   parameter int ROWS  = 500,
   parameter int AMP   = 7,
   parameter int LVL_W = 4,
   localparam int ROW_W = $clog2(ROWS),
   localparam int HALF  = ROWS / 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    tick_i,
   output logic signed [LVL_W-1:0] level_o
);
   logic [ROW_W-1:0]        row_q;
   logic signed [LVL_W-1:0] tbl [ROWS];

   if (ROWS < 4 || (ROWS % 2) != 0) begin : g_bad_rows
      $error("stair_level_table: ROWS must be even and at least 4");
   end

   for (genvar g = 0; g < ROWS; g++) begin : g_row
      localparam int M = stair_pkg::row_mag(g, ROWS, AMP);
      localparam int L = (g >= HALF) ? -M : M;
      assign tbl[g] = LVL_W'(L);
   end

   always_ff @(posedge clk) begin
      if (rst)
         row_q <= '0;
      else if (tick_i)
         row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
   end

   assign level_o = tbl[row_q];

   // R3: the last row is followed by row 0
   p_row_wrap_r3: assert property (@(posedge clk) disable iff (rst)
      tick_i && row_q == ROW_W'(ROWS - 1) |=> row_q == '0);
   // R3: the row index stays inside the table
   p_row_range_r3: assert property (@(posedge clk) disable iff (rst)
      row_q < ROW_W'(ROWS));
endmodule

// File: rtl/stair_gate_decoder.sv
`timescale 1ns/1ps
module stair_gate_decoder #(
   parameter int NUM_UNITS = 2,
   parameter int LVL_W     = 4,
   localparam int UW       = stair_pkg::UNIT_W,
   localparam int MAXMAG   = 3 * NUM_UNITS + 1
) (
   input  logic signed [LVL_W-1:0]  level_i,
   input  logic [3:0]               hb_prev_i,
   output logic [1:0]               aux_o,
   output logic [NUM_UNITS*UW-1:0]  unit_o,
   output logic [3:0]               hb_o
);
   import stair_pkg::*;

   int mag, q, r;

   always_comb begin
      mag = (level_i < 0) ? -int'(level_i) : int'(level_i);
      if (mag > MAXMAG) mag = MAXMAG;
      q = mag / 3;
      r = mag % 3;
      aux_o = (r == 1) ? AUX_ADD : AUX_BYP;
      for (int u = 0; u < NUM_UNITS; u++) begin
         if (u < q)                unit_o[u*UW +: UW] = UNIT_THREE;
         else if (u == q && r == 2) unit_o[u*UW +: UW] = UNIT_TWO;
         else                      unit_o[u*UW +: UW] = UNIT_ZERO;
      end
      if (mag == 0)        hb_o = hb_prev_i;
      else if (level_i < 0) hb_o = HB_NEG;
      else                 hb_o = HB_POS;
   end
endmodule

// File: rtl/stair_short_screen.sv
`timescale 1ns/1ps
module stair_short_screen #(
   parameter int NUM_UNITS = 2,
   localparam int UW       = stair_pkg::UNIT_W
) (
   input  logic [NUM_UNITS*UW-1:0] unit_i,
   output logic [NUM_UNITS*UW-1:0] unit_o,
   output logic                    illegal_o
);
   logic [NUM_UNITS-1:0] bad;

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      assign bad[u] = stair_pkg::short_hazard(unit_i[u*UW +: UW]);
      assign unit_o[u*UW +: UW] = bad[u] ? '0 : unit_i[u*UW +: UW];
   end

   assign illegal_o = |bad;
endmodule

// File: rtl/stair_gate_seq.sv
`timescale 1ns/1ps
module stair_gate_seq #(
   parameter int NUM_UNITS = 2,
   parameter int ROWS      = 500,
   parameter int DIV_W     = 16,
   localparam int UW       = stair_pkg::UNIT_W,
   localparam int MAXMAG   = 3 * NUM_UNITS + 1,
   localparam int LVL_W    = $clog2(MAXMAG + 1) + 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [DIV_W-1:0]        div_i,
   output logic [1:0]              aux_gate_o,
   output logic [NUM_UNITS*UW-1:0] unit_gate_o,
   output logic [3:0]              hb_gate_o,
   output logic                    short_flag_o
);
   import stair_pkg::*;

   if (NUM_UNITS < 1) begin : g_bad_units
      $error("stair_gate_seq: NUM_UNITS must be at least 1");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("stair_gate_seq: DIV_W must be at least 1");
   end

   logic                    tick;
   logic signed [LVL_W-1:0] level;
   logic [1:0]              aux_d, aux_q;
   logic [NUM_UNITS*UW-1:0] unit_raw, unit_d, unit_q;
   logic [3:0]              hb_d, hb_q;
   logic                    illegal, flag_q;

   stair_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst(rst), .div_i(div_i), .tick_o(tick));

   stair_level_table #(.ROWS(ROWS), .AMP(MAXMAG), .LVL_W(LVL_W)) u_table (
      .clk(clk), .rst(rst), .tick_i(tick), .level_o(level));

   stair_gate_decoder #(.NUM_UNITS(NUM_UNITS), .LVL_W(LVL_W)) u_dec (
      .level_i(level), .hb_prev_i(hb_q),
      .aux_o(aux_d), .unit_o(unit_raw), .hb_o(hb_d));

   stair_short_screen #(.NUM_UNITS(NUM_UNITS)) u_screen (
      .unit_i(unit_raw), .unit_o(unit_d), .illegal_o(illegal));

   always_ff @(posedge clk) begin
      if (rst) begin
         aux_q  <= '0;
         unit_q <= '0;
         hb_q   <= HB_OFF;
         flag_q <= 1'b0;
      end else if (tick) begin
         aux_q  <= aux_d;
         unit_q <= unit_d;
         hb_q   <= hb_d;
         flag_q <= illegal;
      end
   end

   assign aux_gate_o   = aux_q;
   assign unit_gate_o  = unit_q;
   assign hb_gate_o    = hb_q;
   assign short_flag_o = flag_q;

   // R10: nothing moves without a strobe
   p_hold_between_rows_r10: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(aux_q) && $stable(unit_q) && $stable(hb_q) && $stable(flag_q));
   // R8: a zero level leaves the bridge as it was
   p_zero_keeps_pol_r8: assert property (@(posedge clk) disable iff (rst)
      tick && level == '0 |=> $stable(hb_q));
   // R6: exactly one auxiliary switch conducts after any row update
   p_aux_complement_r6: assert property (@(posedge clk) disable iff (rst)
      tick |=> $countones(aux_q) == 1);
   // R7: bridge word is off, positive or negative only
   p_hb_legal_r7: assert property (@(posedge clk) disable iff (rst)
      hb_q == HB_OFF || hb_q == HB_POS || hb_q == HB_NEG);

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit_chk
      // R9: no source short on any registered unit word
      p_no_short_r9: assert property (@(posedge clk) disable iff (rst)
         !short_hazard(unit_q[u*UW +: UW]));
   end
endmodule

// File: tb/tb_stair_gate_seq.sv
`timescale 1ns/1ps
module tb_stair_gate_seq;
   localparam int NU   = 2;
   localparam int ROWS = 500;
   localparam int HALF = ROWS / 2;
   localparam int AMP  = 3 * NU + 1;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [15:0]     div = 16'd3;
   logic [1:0]      aux;
   logic [NU*5-1:0] unit;
   logic [3:0]      hb;
   logic            flag;

   int   vecs = 0;
   int   errs = 0;
   int   row  = 0;
   logic [3:0] hb_exp = 4'b0000;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   stair_gate_seq dut (
      .clk(clk), .rst(rst), .div_i(div),
      .aux_gate_o(aux), .unit_gate_o(unit), .hb_gate_o(hb), .short_flag_o(flag));

   // R4 table formula, written from the requirement
   function automatic int exp_level(input int k);
      int t, p, d, m;
      t = (k < HALF) ? k : k - HALF;
      p = t * (HALF - t);
      d = 5 * HALF * HALF - 4 * p;
      m = (32 * p * AMP + d) / (2 * d);
      return (k >= HALF) ? -m : m;
   endfunction

   task automatic check(input string tag, input int got, input int exp);
      vecs++;
      if (got != exp) begin
         errs++;
         $display("FAIL %s row %0d: actual %0h expected %0h", tag, row, got, exp);
      end
   endtask

   // R3 row order: compare against the next expected row, then advance
   task automatic check_row();
      int lv, m, q, r;
      logic [1:0]      ae;
      logic [NU*5-1:0] ue;
      lv = exp_level(row);
      m  = (lv < 0) ? -lv : lv;
      q  = m / 3;
      r  = m % 3;
      ae = (r == 1) ? 2'b01 : 2'b10;
      for (int u = 0; u < NU; u++)
         ue[u*5 +: 5] = (u < q) ? 5'b00111 : ((u == q && r == 2) ? 5'b01101 : 5'b10000);
      if (m != 0) hb_exp = (lv < 0) ? 4'b0110 : 4'b1001;
      check("R3 R4 R5 units", int'(unit), int'(ue));
      check("R6 aux", int'(aux), int'(ae));
      check((m == 0) ? "R8 bridge hold" : "R7 bridge", int'(hb), int'(hb_exp));
      check("R9 flag", int'(flag), 0);
      row = (row + 1) % ROWS;
   endtask

   // entered and left at a negedge right after a strobe
   task automatic run_rows(input int d, input int n);
      int eff;
      logic [15:0] snap;
      div = 16'(d);
      eff = (d == 0) ? 1 : d;
      for (int i = 0; i < n; i++) begin
         if (eff > 1) begin
            snap = {aux, unit, hb};
            @(posedge clk);
            @(negedge clk);
            check("R10 hold", int'({aux, unit, hb}), int'(snap));
            check("R2 no early update", int'({aux, unit, hb}), int'(snap));
            repeat (eff - 1) @(posedge clk);
         end else begin
            @(posedge clk);
         end
         @(negedge clk);
         check_row();
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset gates", int'({aux, unit, hb}), 0);
      check("R1 reset flag", int'(flag), 0);
      rst = 1'b0;
      run_rows(3, 600);   // crosses both zero crossings and one wrap
      run_rows(1, 50);    // R2 strobe every clock
      run_rows(0, 20);    // R2 zero divider acts as one
      run_rows(5, 450);   // second wrap at a slower rate
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      #(150000 * 5);
      if (!done) begin
         vecs++;
         errs++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end
endmodule